// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit down-counting channel of an interval timer. It advances only in clock cycles where a clock enable (`tick_en`) is high, so one shared fast clock can drive channels at any slower rate. The counter can work in plain binary or in four-digit packed BCD. It offers six counting modes: a terminal-count event, a gate-triggered one-shot, a rate generator, a square-wave generator, and a single strobe started by software or by a gate edge. A gate input either suspends counting or retriggers it, depending on the mode. The block drives one waveform output.

A register interface in the surrounding design writes a new initial count, a 3-bit mode field and a BCD flag with a one-cycle strobe. The strobe has no ready signal. The channel accepts it in any cycle, and it takes priority over everything else in that cycle, so there is never back-pressure. The live count and the waveform level are always visible at the outputs.

An initial count of zero stands for the largest period: 65536 ticks in binary and 10000 ticks in BCD. The event and strobe modes keep counting past zero and wrap. The rate and square-wave modes reload the initial count at the end of each period.

Top module: `interval_counter_channel`

## Requirements
- R1: In the cycle after a load strobe, `wave_o` takes the idle level of the new mode: high for modes 1 and 3, low for modes 0, 2, 4 and 5. In modes 0, 2, 3 and 4, the first `tick_en` cycle after the load cycle copies the initial count into the counter, whatever the gate level.
- R2: A loaded count of 0 gives a full period of 65536 ticks in binary and 10000 ticks in BCD (`load_bcd`=1).
- R3: In modes 0, 1, 4 and 5 the counter does not stop at zero. It wraps to 0xFFFF in binary or 0x9999 in BCD and keeps decrementing.
- R4: In BCD mode each 4-bit digit of `count_o` (digit 0 in bits 3:0, digit 3 in bits 15:12) stays within 0 to 9, and a borrow passes to the next digit up.
- R5: Mode 0 (`load_mode`=0): `wave_o` is low after the load and goes high after the initial count N has been counted down. It then stays high until the next load.
- R6: Mode 1: a gate rising edge starts a one-shot. `wave_o` goes low on the starting tick and goes high again N counted ticks later, where it stays.
- R7: Mode 2: the counter reloads N every N counted ticks. `wave_o` is high for exactly the one tick on which the reload happens, and is otherwise low.
- R8: Mode 3: the counter steps down by two per tick. `wave_o` is high for the first ceil(N/2) ticks of each N-tick period and low for the rest. It is high in the cycle after the load.
- R9: Modes 4 and 5: `wave_o` is high for exactly one tick, on the N-th counted tick after the start, and only once per start. Mode 5 starts on a gate rising edge.
- R10: In modes 0, 2, 3 and 4, a tick with `gate` low does not count. In mode 2 such a tick also drives `wave_o` low. In modes 1, 2, 3 and 5, a gate rising edge restarts the count from N on the next tick. An edge seen between ticks is remembered until that tick.
- R11: Mode field values 6 and 7 act exactly as modes 2 and 3.
- R12: In a cycle with `tick_en` low and no load strobe, neither `count_o` nor `wave_o` changes.
- R13: After reset, `count_o` is 0 and `wave_o` is low. Both stay that way until a count is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counting clock enable; one counting step per high cycle |
| gate | input | 1 | Gate level; suspends or retriggers counting depending on mode |
| load_stb | input | 1 | One-cycle strobe that writes a new count, mode and coding; always accepted |
| load_count | input | 16 | Initial count, binary or packed BCD; 0 means the maximum |
| load_mode | input | 3 | Mode field; 6 and 7 alias 2 and 3 |
| load_bcd | input | 1 | 1 selects four-digit BCD counting |
| count_o | output | 16 | Live counter value |
| wave_o | output | 1 | Channel waveform output |

## Verification
The assertions check, on every cycle, the rules that need only a short view of time. Without a tick or a load the state holds. A mode-0 high level stays high, and a mode-4/5 pulse lasts one tick. The mode-2 pulse coincides with the reload value. A square-wave load starts high, and a gate edge between ticks is kept. Periods, pulse positions, wrap values, BCD digit borrows and the zero-means-maximum case depend on how many ticks have passed. Only the bench's scenarios can show these, and it sweeps every mode against an arithmetic count of elapsed ticks under several gate and tick patterns.

// File: rtl/ictr_pkg.sv
package ictr_pkg;

  typedef enum logic [2:0] {
    MD_EVENT    = 3'd0,
    MD_ONESHOT  = 3'd1,
    MD_RATE     = 3'd2,
    MD_SQUARE   = 3'd3,
    MD_SWSTROBE = 3'd4,
    MD_HWSTROBE = 3'd5
  } ictr_mode_e;

  // Field values 6 and 7 fold onto the rate and square-wave modes.
  function automatic ictr_mode_e fold_mode(input logic [2:0] field);
    if (field[2:1] == 2'b11) return ictr_mode_e'({1'b0, field[1:0]});
    return ictr_mode_e'(field);
  endfunction

endpackage

// File: rtl/ictr_decrement.sv
// Subtracts a fixed step from a count, in binary or packed BCD, wrapping below zero.
module ictr_decrement #(
  parameter int W    = 16,
  parameter int STEP = 1
) (
  input  logic [W-1:0] val,
  input  logic         bcd,
  output logic [W-1:0] res
);
  localparam int DIGITS = W / 4;

  logic [W-1:0] bin_res;
  logic [W-1:0] bcd_res;
  logic [DIGITS:1] borrow;

  assign bin_res = val - W'(STEP);

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    logic [4:0] d, sub, diff;
    logic       bneed;
    assign d = {1'b0, val[4*i +: 4]};
    if (i == 0) begin : g_first
      assign sub = 5'(STEP);
    end else begin : g_rest
      assign sub = {4'b0, borrow[i]};
    end
    assign bneed = (d < sub);
    assign diff  = bneed ? (d + 5'd10 - sub) : (d - sub);
    assign bcd_res[4*i +: 4] = diff[3:0];
    if (i < DIGITS - 1) begin : g_chain
      assign borrow[i+1] = bneed;
    end
  end

  if (DIGITS > 1) begin : g_top_unused
    assign borrow[DIGITS] = 1'b0;
  end else begin : g_single
    assign borrow[1] = 1'b0;
  end

  assign res = bcd ? bcd_res : bin_res;

endmodule

// File: rtl/ictr_trigger.sv
// Gate rising-edge detector with a latch that holds an edge until the next tick.
module ictr_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  input  logic tick_en,
  input  logic clear,
  output logic trig
);
  logic gate_q;
  logic held_q;
  logic rise;

  assign rise = gate & ~gate_q;
  assign trig = held_q | rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      held_q <= 1'b0;
    end else begin
      gate_q <= gate;
      if (clear)        held_q <= 1'b0;
      else if (tick_en) held_q <= 1'b0;
      else if (rise)    held_q <= 1'b1;
    end
  end

  // R10: an edge arriving between ticks is still visible on the following cycle
  p_edge_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && !gate_q && !tick_en && !clear) |=> trig);

endmodule

// File: rtl/ictr_core.sv
// Configuration registers, counter and waveform state of one channel.
module ictr_core
  import ictr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         gate,
  input  logic         trig,
  input  logic         load_stb,
  input  logic [W-1:0] load_count,
  input  logic [2:0]   load_mode,
  input  logic         load_bcd,
  output logic [W-1:0] count_o,
  output logic         wave_o
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);
  localparam int NSTEP = 2;

  ictr_mode_e   mode_q, new_mode;
  logic         bcd_q;
  logic [W-1:0] init_q, cnt_q, even_init;
  logic         out_q, run_q, pend_q, fired_q, hi_q;
  logic [W-1:0] dec_res [NSTEP];

  logic waits_trig, retrig_md, gated_md, pulse_md;
  logic start, cnt_en, hit1, sq_term;

  for (genvar s = 0; s < NSTEP; s++) begin : g_dec
    ictr_decrement #(.W(W), .STEP(s + 1)) u_dec (
      .val(cnt_q),
      .bcd(bcd_q),
      .res(dec_res[s])
    );
  end

  assign new_mode   = fold_mode(load_mode);
  assign waits_trig = (mode_q == MD_ONESHOT) || (mode_q == MD_HWSTROBE);
  assign retrig_md  = waits_trig || (mode_q == MD_RATE) || (mode_q == MD_SQUARE);
  assign gated_md   = !waits_trig;
  assign pulse_md   = (mode_q == MD_RATE) || (mode_q == MD_SWSTROBE) || (mode_q == MD_HWSTROBE);
  assign even_init  = {init_q[W-1:1], 1'b0};

  assign start   = tick_en && ((pend_q && !waits_trig) || (trig && retrig_md && (run_q || pend_q)));
  assign cnt_en  = gated_md ? gate : 1'b1;
  assign hit1    = (cnt_q == ONE);
  assign sq_term = (hi_q && init_q[0]) ? (cnt_q == '0) : (cnt_q == TWO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MD_EVENT;
      bcd_q   <= 1'b0;
      init_q  <= '0;
      cnt_q   <= '0;
      out_q   <= 1'b0;
      run_q   <= 1'b0;
      pend_q  <= 1'b0;
      fired_q <= 1'b0;
      hi_q    <= 1'b1;
    end else if (load_stb) begin
      mode_q  <= new_mode;
      bcd_q   <= load_bcd;
      init_q  <= load_count;
      pend_q  <= 1'b1;
      run_q   <= 1'b0;
      fired_q <= 1'b0;
      hi_q    <= 1'b1;
      out_q   <= (new_mode == MD_ONESHOT) || (new_mode == MD_SQUARE);
    end else if (start) begin
      pend_q  <= 1'b0;
      run_q   <= 1'b1;
      fired_q <= 1'b0;
      hi_q    <= 1'b1;
      cnt_q   <= (mode_q == MD_SQUARE) ? even_init : init_q;
      out_q   <= (mode_q == MD_SQUARE);
    end else if (tick_en && run_q) begin
      if (pulse_md) out_q <= 1'b0;
      if (cnt_en) begin
        if (mode_q == MD_RATE) begin
          if (hit1) begin
            cnt_q <= init_q;
            out_q <= 1'b1;
          end else begin
            cnt_q <= dec_res[0];
          end
        end else if (mode_q == MD_SQUARE) begin
          if (sq_term) begin
            hi_q  <= ~hi_q;
            out_q <= ~hi_q;
            cnt_q <= even_init;
          end else begin
            cnt_q <= dec_res[1];
          end
        end else begin
          cnt_q <= dec_res[0];
          if (hit1 && !fired_q) begin
            out_q   <= 1'b1;
            fired_q <= 1'b1;
          end
        end
      end
    end
  end

  assign count_o = cnt_q;
  assign wave_o  = out_q;

  // R12: nothing moves without a tick or a load
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !load_stb) |=> ($stable(cnt_q) && $stable(out_q)));

  // R5: a mode-0 high output stays high until the next load
  p_event_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_EVENT && out_q && !load_stb) |=> out_q);

  // R9: a strobe pulse lasts a single tick
  p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MD_SWSTROBE || mode_q == MD_HWSTROBE) && out_q && tick_en && !load_stb) |=> !out_q);

  // R7: the rate pulse coincides with the reloaded count
  p_rate_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_RATE && out_q) |-> (cnt_q == init_q));

  // R8: loading the square-wave mode raises the output
  p_square_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && fold_mode(load_mode) == MD_SQUARE) |=> out_q);

endmodule

// File: rtl/interval_counter_channel.sv
module interval_counter_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             gate,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] load_count,
  input  logic [2:0]       load_mode,
  input  logic             load_bcd,
  output logic [CNT_W-1:0] count_o,
  output logic             wave_o
);
  logic trig;

  ictr_trigger u_trig (
    .clk    (clk),
    .rst_n  (rst_n),
    .gate   (gate),
    .tick_en(tick_en),
    .clear  (load_stb),
    .trig   (trig)
  );

  ictr_core #(.W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .gate      (gate),
    .trig      (trig),
    .load_stb  (load_stb),
    .load_count(load_count),
    .load_mode (load_mode),
    .load_bcd  (load_bcd),
    .count_o   (count_o),
    .wave_o    (wave_o)
  );

endmodule

// File: tb/interval_counter_channel_tb_top.sv
module interval_counter_channel_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        gate = 1'b0;
  logic        load_stb = 1'b0;
  logic [15:0] load_count = '0;
  logic [2:0]  load_mode = '0;
  logic        load_bcd = 1'b0;
  logic [15:0] count_o;
  logic        wave_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model of elapsed ticks
  int mm, neff, k;
  bit mb, running, pend, counted, trigl, gp;

  always #4 clk = ~clk;

  interval_counter_channel dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate(gate),
    .load_stb(load_stb), .load_count(load_count), .load_mode(load_mode),
    .load_bcd(load_bcd), .count_o(count_o), .wave_o(wave_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  function automatic int enc(input int v, input bit b);
    if (!b) return v & 65535;
    return (v % 10) | (((v / 10) % 10) << 4) | (((v / 100) % 10) << 8) | (((v / 1000) % 10) << 12);
  endfunction

  function automatic int idle_lvl(input int m);
    return (m == 1 || m == 3) ? 1 : 0;
  endfunction

  task automatic report();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // one clock: drive at negedge, update model for the coming edge, sample at next negedge
  task automatic cyc(input bit t, input bit g, input string tag);
    bit rise, trg, wt, rt, gt;
    int modv, eo;
    tick_en = t;
    gate    = g;
    rise = g && !gp;
    gp   = g;
    wt = (mm == 1 || mm == 5);
    rt = wt || mm == 2 || mm == 3;
    gt = !wt;
    if (t) begin
      trg = trigl || rise;
      trigl = 0;
      if ((pend && !wt) || (trg && rt && (running || pend))) begin
        k = 0; running = 1; pend = 0; counted = 0;
      end else if (running) begin
        if (!gt || g) begin k++; counted = 1; end
        else counted = 0;
      end
    end else if (rise) begin
      trigl = 1;
    end
    @(negedge clk);
    if (!running) begin
      chk(tag, wave_o, idle_lvl(mm));
    end else begin
      modv = mb ? 10000 : 65536;
      case (mm)
        0, 1: eo = (k >= neff);
        2: eo = (counted && k > 0 && (k % neff) == 0);
        3: eo = ((k % neff) < (neff + 1) / 2);
        default: eo = (counted && k == neff);
      endcase
      chk(tag, wave_o, eo);
      if (mm == 2)
        chk(tag, count_o, enc((neff - (k % neff)) % modv, mb));
      else if (mm == 3) begin
        if ((neff % 2) == 0)
          chk(tag, count_o, enc((neff - 2 * (k % (neff / 2))) % modv, mb));
      end else
        chk(tag, count_o, enc((((neff - k) % modv) + modv) % modv, mb));
    end
  endtask

  // pat 0: steady; 1: gate low 2 of 7 cycles; 2: tick every third cycle; 3: one gate dip at i=10
  task automatic run_case(input int mf, input int nval, input bit b, input string tag,
                          input int pat, input int len);
    mm   = (mf >= 6) ? mf - 4 : mf;
    mb   = b;
    neff = (nval == 0) ? (b ? 10000 : 65536) : nval;
    load_stb   = 1'b1;
    load_count = 16'(enc(nval, b));
    load_mode  = 3'(mf);
    load_bcd   = b;
    tick_en    = 1'b0;
    gate       = (mm == 1 || mm == 5) ? 1'b0 : 1'b1;
    @(negedge clk);
    load_stb = 1'b0;
    gp = gate; pend = 1; running = 0; trigl = 0; counted = 0; k = 0;
    @(negedge clk);
    chk("R1", wave_o, idle_lvl(mm));
    for (int i = 0; i < len; i++) begin
      case (pat)
        1: cyc(1'b1, (i % 7) < 5, tag);
        2: cyc((i % 3) == 2, 1'b1, tag);
        3: cyc(1'b1, i != 10, tag);
        default: cyc(1'b1, 1'b1, tag);
      endcase
    end
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13", count_o, 0);
    chk("R13", wave_o, 0);
    tick_en = 1'b1; gate = 1'b1;
    repeat (4) @(negedge clk);
    chk("R13", count_o, 0);
    chk("R13", wave_o, 0);

    run_case(0, 5, 0, "R5", 0, 20);
    run_case(0, 5, 0, "R10", 1, 20);
    run_case(0, 3, 1, "R4", 0, 12);
    run_case(0, 4, 0, "R12", 2, 24);
    run_case(1, 4, 0, "R6", 0, 15);
    run_case(1, 2, 0, "R3", 0, 10);
    run_case(1, 4, 0, "R10", 3, 20);
    run_case(1, 3, 0, "R10", 2, 30);
    run_case(2, 5, 0, "R7", 0, 22);
    run_case(2, 2, 0, "R7", 0, 10);
    run_case(2, 5, 0, "R10", 1, 30);
    run_case(2, 4, 0, "R12", 2, 30);
    run_case(2, 12, 1, "R4", 0, 40);
    run_case(6, 4, 0, "R11", 0, 15);
    run_case(3, 6, 0, "R8", 0, 20);
    run_case(3, 7, 0, "R8", 0, 25);
    run_case(3, 5, 0, "R10", 1, 30);
    run_case(7, 5, 0, "R11", 0, 16);
    run_case(3, 10, 1, "R4", 0, 25);
    run_case(4, 4, 0, "R9", 0, 20);
    run_case(4, 2, 0, "R3", 0, 8);
    run_case(4, 6, 0, "R10", 1, 25);
    run_case(5, 3, 0, "R9", 0, 12);
    run_case(5, 6, 0, "R10", 3, 25);
    run_case(5, 20, 1, "R4", 0, 30);
    run_case(0, 0, 1, "R2", 0, 10003);
    run_case(0, 0, 0, "R2", 0, 65540);
    report();
  end

endmodule